// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block reprograms one clock-generation PLL in a fixed, safe order from a single start request. While idle it owns the PLL settings register and mirrors the PLL lock flag into it. When started with the PLL marked present, it captures the new settings word. It then moves the downstream clock multiplexer onto the fixed reference clock and closes the PLL output gate. Next it writes the configuration fields and waits for lock. After lock it reopens the gate, returns the multiplexer to the PLL and pulses done.

The settings word carries six fields: reference divider R, feedback divider F, output divider Q, filter range, bypass and feedback-path select. The synthesized frequency is reference / (R+1) x 2(F+1) / 2^Q. For example, a 26 MHz reference with R=0, F=76 and Q=2 gives roughly 1001 MHz. A programmable timeout stops a wait for a lock that never comes. When that happens the clock stays parked on the reference and the gate stays closed.

Top module: `pll_reprog_seq`

## Requirements
- R1: During reset the block drives `mux_sel_o`=0, `gate_en_o`=1, `busy_o`=0, `done_o`=0 and `err_o`=0. `pll_cfg_o[30:0]` holds 31'h2860_0000 and `pll_cfg_o[31]` is 0.
- R2: A start with `present_i`=1 sets `busy_o` at the accepting edge. `mux_sel_o` becomes 1 (reference clock) one edge later. `gate_en_o` becomes 0 on the next edge, and the settings register is written on the edge after that.
- R3: A write replaces only the configuration fields: R in bits 5:0, F in bits 14:6, Q in bits 17:15, range in bits 20:18, bypass in bit 24 and feedback-path select in bit 25 (mask 31'h031F_FFFF). Bits 21-23 and 26-30 keep their old values.
- R4: `pll_cfg_o[31]` is the lock flag, equal to `lock_i` delayed by one clock. After the write the block keeps the gate closed and the multiplexer on the reference until this flag reads 1.
- R5: The gate reopens two edges after the lock flag first reads 1. One edge later `mux_sel_o` returns to 0 and `done_o` pulses while `busy_o` clears. With the lock input low for d cycles after the write, `busy_o` stays high for 7+d cycles.
- R6: A start with `present_i`=0 raises `done_o` on the very next edge and never raises `busy_o`. The settings register, multiplexer select and gate are left as they were.
- R7: If lock is not seen, the wait ends when the timeout counter reaches `tmo_limit_i`. `busy_o` then lasts exactly 4+limit cycles, `err_o` is set and `done_o` pulses, with the multiplexer left at 1 and the gate at 0. The next accepted start clears `err_o`.
- R8: A start request while `busy_o` is high is ignored: it produces no second done pulse and does not lengthen the sequence.
- R9: `done_o` is high for exactly one cycle per finished request.
- R10: The settings word is captured when start is accepted; later changes to `new_cfg_i` do not affect the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a reprogramming sequence |
| present_i | input | 1 | 1 when the PLL exists; 0 makes a request finish at once |
| new_cfg_i | input | 31 | New settings word (writable bits of the register) |
| lock_i | input | 1 | Lock indication from the PLL |
| tmo_limit_i | input | TMO_W | Lock-wait limit in clock cycles |
| pll_cfg_o | output | 32 | Settings register; bit 31 is the lock flag |
| mux_sel_o | output | 1 | Clock multiplexer select: 1 reference, 0 PLL |
| gate_en_o | output | 1 | PLL output gate enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last sequence ended by timeout |

## Verification
Two functions can land on the same edge: the lock flag rising and the lock-wait timeout. A stray start request can also arrive in the middle of a running sequence. The bench provokes the first case by holding the modelled lock low so that the timer expires. It then judges the exact busy length, the error flag and the parked multiplexer and gate state. It provokes the second case by pulsing start with different settings while busy, then checks that only one done pulse appears. The written value must come from the first request and the busy length must match an undisturbed run.

// File: rtl/pll_reprog_pkg.sv
`timescale 1ns/1ps
package pll_reprog_pkg;

  // Writable width of the settings register; bit 31 is the lock flag.
  localparam int WR_W = 31;

  // Configuration fields: divr 5:0, divf 14:6, divq 17:15, range 20:18,
  // bypass 24, feedback-path 25.
  localparam logic [WR_W-1:0] FIELD_MASK = 31'h031F_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_AWAY   = 3'd1,
    ST_GATE   = 3'd2,
    ST_PROG   = 3'd3,
    ST_WAIT   = 3'd4,
    ST_UNGATE = 3'd5,
    ST_BACK   = 3'd6
  } seq_state_t;

  function automatic logic [WR_W-1:0] apply_fields(input logic [WR_W-1:0] cur,
                                                   input logic [WR_W-1:0] upd);
    return (cur & ~FIELD_MASK) | (upd & FIELD_MASK);
  endfunction

endpackage

// File: rtl/pll_cfg_reg.sv
`timescale 1ns/1ps
module pll_cfg_reg
  import pll_reprog_pkg::*;
#(
  parameter logic [WR_W-1:0] CFG_INIT = 31'h2860_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WR_W-1:0] upd_i,
  input  logic            lock_i,
  output logic            lock_q_o,
  output logic [WR_W:0]   cfg_o
);

  logic [WR_W-1:0] cfg_q;
  logic            lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_INIT;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_i;
      if (wr_en) begin
        cfg_q <= apply_fields(cfg_q, upd_i);
      end
    end
  end

  assign lock_q_o = lock_q;
  assign cfg_o    = {lock_q, cfg_q};

  AST_KEEP_OTHER_BITS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((cfg_q & ~FIELD_MASK) == ($past(cfg_q) & ~FIELD_MASK))); // R3

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/pll_lock_timer.sv
`timescale 1ns/1ps
module pll_lock_timer #(
  parameter int CNT_W  = 16,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit_i,
  output logic             settle_ok_o,
  output logic             expired_o
);

  localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settle_ok_o = (cnt_q >= SETTLE_V);
  assign expired_o   = (cnt_q >= limit_i);

endmodule

// File: rtl/pll_seq_fsm.sv
`timescale 1ns/1ps
module pll_seq_fsm
  import pll_reprog_pkg::*;
#(
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            present_i,
  input  logic [WR_W-1:0] cfg_i,
  input  logic            lock_q_i,
  input  logic            settle_ok_i,
  input  logic            expired_i,
  output logic            tmr_clear_o,
  output logic            tmr_run_o,
  output logic            cfg_wr_o,
  output logic [WR_W-1:0] hold_o,
  output logic            mux_o,
  output logic            gate_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);

  seq_state_t      state_q;
  logic [WR_W-1:0] hold_q;
  logic            busy_q, done_q, err_q;
  logic            mux_q, gate_q;
  logic            mux_set, mux_clr, gate_clr, gate_set;

  always_comb begin
    mux_set     = (state_q == ST_AWAY);
    mux_clr     = (state_q == ST_BACK);
    gate_clr    = (state_q == ST_GATE);
    gate_set    = (state_q == ST_UNGATE);
    cfg_wr_o    = (state_q == ST_PROG);
    tmr_clear_o = (state_q == ST_PROG);
    tmr_run_o   = (state_q == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (present_i) begin
              hold_q  <= cfg_i;
              busy_q  <= 1'b1;
              err_q   <= 1'b0;
              state_q <= ST_AWAY;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_AWAY:   state_q <= ST_GATE;
        ST_GATE:   state_q <= ST_PROG;
        ST_PROG:   state_q <= ST_WAIT;
        ST_WAIT: begin
          if (settle_ok_i && lock_q_i) begin
            state_q <= ST_UNGATE;
          end else if (expired_i) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_UNGATE: state_q <= ST_BACK;
        ST_BACK: begin
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (HAS_MUX) begin : g_mux
      always_ff @(posedge clk) begin
        if (rst)          mux_q <= 1'b0;
        else if (mux_set) mux_q <= 1'b1;
        else if (mux_clr) mux_q <= 1'b0;
      end
    end else begin : g_no_mux
      assign mux_q = 1'b0;
    end

    if (HAS_GATE) begin : g_gate
      always_ff @(posedge clk) begin
        if (rst)           gate_q <= 1'b1;
        else if (gate_clr) gate_q <= 1'b0;
        else if (gate_set) gate_q <= 1'b1;
      end
    end else begin : g_no_gate
      assign gate_q = 1'b1;
    end
  endgenerate

  assign hold_o = hold_q;
  assign mux_o  = mux_q;
  assign gate_o = gate_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R9

  AST_ABSENT_SKIP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && !present_i) |=> (done_q && !busy_q && $stable(mux_q) && $stable(gate_q))); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(hold_q)); // R10

  AST_UNGATE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(lock_q_i)); // R4

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy_q && state_q != ST_BACK && state_q != ST_WAIT) |=> busy_q); // R8

endmodule

// File: rtl/pll_reprog_seq.sv
`timescale 1ns/1ps
module pll_reprog_seq
  import pll_reprog_pkg::*;
#(
  parameter logic [30:0] CFG_INIT = 31'h2860_0000,
  parameter int          TMO_W    = 16,
  parameter int          SETTLE   = 2,
  parameter bit          HAS_MUX  = 1'b1,
  parameter bit          HAS_GATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             present_i,
  input  logic [30:0]      new_cfg_i,
  input  logic             lock_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic [31:0]      pll_cfg_o,
  output logic             mux_sel_o,
  output logic             gate_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  logic            tmr_clear, tmr_run, cfg_wr;
  logic            settle_ok, expired, lock_q;
  logic [WR_W-1:0] hold;

  pll_seq_fsm #(
    .HAS_MUX  (HAS_MUX),
    .HAS_GATE (HAS_GATE)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .present_i   (present_i),
    .cfg_i       (new_cfg_i),
    .lock_q_i    (lock_q),
    .settle_ok_i (settle_ok),
    .expired_i   (expired),
    .tmr_clear_o (tmr_clear),
    .tmr_run_o   (tmr_run),
    .cfg_wr_o    (cfg_wr),
    .hold_o      (hold),
    .mux_o       (mux_sel_o),
    .gate_o      (gate_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  pll_lock_timer #(
    .CNT_W  (TMO_W),
    .SETTLE (SETTLE)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .clear       (tmr_clear),
    .run         (tmr_run),
    .limit_i     (tmo_limit_i),
    .settle_ok_o (settle_ok),
    .expired_o   (expired)
  );

  pll_cfg_reg #(
    .CFG_INIT (CFG_INIT)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .upd_i    (hold),
    .lock_i   (lock_i),
    .lock_q_o (lock_q),
    .cfg_o    (pll_cfg_o)
  );

  AST_GATE_UNDER_REF: assert property (@(posedge clk) disable iff (rst)
    (HAS_MUX && !gate_en_o) |-> mux_sel_o); // R2

  AST_WRITE_SAFE: assert property (@(posedge clk) disable iff (rst)
    (HAS_MUX && HAS_GATE && !$stable(pll_cfg_o[30:0])) |-> (mux_sel_o && !gate_en_o)); // R2

  AST_ERR_PARKED: assert property (@(posedge clk) disable iff (rst)
    (HAS_MUX && HAS_GATE && $rose(err_o)) |-> (mux_sel_o && !gate_en_o && done_o)); // R7

endmodule

// File: tb/pll_reprog_seq_bench.sv
`timescale 1ns/1ps
module pll_reprog_seq_bench;

  localparam logic [30:0] INIT = 31'h2860_0000;
  localparam logic [30:0] MASK = 31'h031F_FFFF;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, present = 1'b1, lock = 1'b1;
  logic [30:0] cfg_in = '0;
  logic [15:0] limit = 16'd200;
  logic [31:0] pll_cfg;
  logic        mux_sel, gate_en, busy, done, err;

  pll_reprog_seq u_pll_reprog_seq (
    .clk (clk), .rst (rst), .start_i (start), .present_i (present),
    .new_cfg_i (cfg_in), .lock_i (lock), .tmo_limit_i (limit),
    .pll_cfg_o (pll_cfg), .mux_sel_o (mux_sel), .gate_en_o (gate_en),
    .busy_o (busy), .done_o (done), .err_o (err)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int ev_busy, ev_mux1, ev_gate0, ev_cfg, ev_lk, ev_gate1, ev_mux0, ev_done;
  int done_cnt, busy_cnt, lock_dly = 4, lcnt = 0;
  bit hang = 1'b0;
  logic        pbusy = 0, pmux = 0, pgate = 1, plk = 0;
  logic [30:0] pcfg = INIT;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] merged(input logic [30:0] cur, input logic [30:0] upd);
    return (cur & ~MASK) | (upd & MASK);
  endfunction

  // Event monitor and PLL lock model, both on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (busy && !pbusy) ev_busy = cyc;
    if (mux_sel && !pmux) ev_mux1 = cyc;
    if (!gate_en && pgate) ev_gate0 = cyc;
    if (gate_en && !pgate) ev_gate1 = cyc;
    if (!mux_sel && pmux) ev_mux0 = cyc;
    if (pll_cfg[31] && !plk) ev_lk = cyc;
    if (done) begin done_cnt++; ev_done = cyc; end
    if (pll_cfg[30:0] != pcfg) begin
      ev_cfg = cyc;
      lock = 1'b0;
      lcnt = lock_dly;
    end else if (lcnt > 0) begin
      lcnt--;
      if (lcnt == 0 && !hang) lock = 1'b1;
    end
    pbusy = busy; pmux = mux_sel; pgate = gate_en; plk = pll_cfg[31]; pcfg = pll_cfg[30:0];
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_ev();
    ev_busy = -1; ev_mux1 = -1; ev_gate0 = -1; ev_cfg = -1; ev_lk = -1;
    ev_gate1 = -1; ev_mux0 = -1; ev_done = -1; done_cnt = 0; busy_cnt = 0;
  endtask

  task automatic run_start(input logic [30:0] c);
    tick();
    cfg_in = c;
    start  = 1'b1;
    tick();
    start  = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) tick();
    tick();
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1", "mux", {31'd0, mux_sel}, 32'd0);
    chk("R1", "gate", {31'd0, gate_en}, 32'd1);
    chk("R1", "busy/done/err", {29'd0, busy, done, err}, 32'd0);
    chk("R1", "cfg", pll_cfg, {1'b0, INIT});
    rst = 1'b0;
    tick(); tick();
    chk("R4", "lock flag mirrors input", {31'd0, pll_cfg[31]}, 32'd1);
  endtask

  task automatic t_sequence(input logic [30:0] c, input int dly);
    logic [30:0] cur;
    cur = pll_cfg[30:0];
    lock_dly = dly;
    clear_ev();
    run_start(c);
    wait_done();
    chk("R2", "mux to reference after busy", ev_mux1, ev_busy + 1);
    chk("R2", "gate closed after mux", ev_gate0, ev_mux1 + 1);
    chk("R2", "write after gate", ev_cfg, ev_gate0 + 1);
    chk("R4", "lock flag delay", ev_lk, ev_cfg + dly + 1);
    chk("R5", "ungate after lock", ev_gate1, ev_lk + 2);
    chk("R5", "mux back after ungate", ev_mux0, ev_gate1 + 1);
    chk("R5", "done with mux back", ev_done, ev_mux0);
    chk("R5", "busy length", busy_cnt, 7 + dly);
    chk("R9", "single done", done_cnt, 1);
    chk("R3", "merged settings", {1'b1, merged(cur, c)}, pll_cfg);
    chk("R5", "final state", {28'd0, mux_sel, gate_en, busy, err}, 32'b0100);
  endtask

  task automatic t_absent();
    logic [30:0] cur;
    cur = pll_cfg[30:0];
    present = 1'b0;
    tick();
    cfg_in = 31'h7FFF_FFFF;
    start  = 1'b1;
    tick();
    start  = 1'b0;
    chk("R6", "done at once", {30'd0, done, busy}, 32'b10);
    tick();
    chk("R9", "done drops", {31'd0, done}, 32'd0);
    chk("R6", "cfg untouched", {1'b0, pll_cfg[30:0]}, {1'b0, cur});
    chk("R6", "mux/gate untouched", {30'd0, mux_sel, gate_en}, 32'b01);
    tick(); tick(); tick();
    chk("R6", "still idle", {31'd0, busy}, 32'd0);
    present = 1'b1;
  endtask

  task automatic t_busy_ignore();
    logic [30:0] cur;
    cur = pll_cfg[30:0];
    lock_dly = 4;
    clear_ev();
    run_start(31'h00A5_5A5A);
    tick(); tick();
    cfg_in = 31'h7FFF_FFFF;
    start  = 1'b1;
    tick();
    start  = 1'b0;
    wait_done();
    chk("R8", "one done pulse", done_cnt, 1);
    chk("R8", "busy length undisturbed", busy_cnt, 11);
    chk("R10", "first settings written", {1'b0, pll_cfg[30:0]}, {1'b0, merged(cur, 31'h00A5_5A5A)});
  endtask

  task automatic t_timeout(input logic [15:0] lim);
    hang  = 1'b1;
    limit = lim;
    clear_ev();
    run_start(31'h0100_0041);
    wait_done();
    chk("R7", "busy length", busy_cnt, 4 + int'(lim));
    chk("R7", "error flag", {31'd0, err}, 32'd1);
    chk("R7", "parked mux/gate", {30'd0, mux_sel, gate_en}, 32'b10);
    chk("R9", "single done", done_cnt, 1);
    hang  = 1'b0;
    limit = 16'd200;
  endtask

  task automatic t_recover();
    clear_ev();
    lock_dly = 3;
    run_start(31'h0213_0000);
    chk("R7", "error cleared on start", {31'd0, err}, 32'd0);
    wait_done();
    chk("R5", "recovered state", {28'd0, mux_sel, gate_en, busy, err}, 32'b0100);
    chk("R9", "single done", done_cnt, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_ev();
    t_reset();
    t_sequence(31'h7FFF_FFFF, 5);
    t_sequence(31'h0000_0000, 3);
    t_sequence(31'h0211_1300, 6);
    t_absent();
    t_busy_ignore();
    t_timeout(16'd10);
    t_recover();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule